// File: doc/BRIEF.md
# Voice Codec PCM Serial Port

This block is the digital serial side of a single-channel voice codec. Once per frame it receives one 8-bit companded sample from a serial data line and hands it to the decoder. In the same frame it takes one 8-bit sample from the encoder and shifts it out. The receive and transmit directions each have their own short sync strobe. A sync strobe is high for one bit-clock period, and the most significant bit follows in the next period. The bit clock sets the data rate, typically 64 kHz to 2.048 MHz at an 8 kHz frame rate. A coding-law select bit travels with every received word.

All pins are oversampled in a free-running system clock domain through a multi-flop synchronizer. Receive bits are taken on bit-clock falling edges. Transmit bits change on rising edges. Outside its eight-bit slot the transmit line is released; the pad applies `tx_oe` as the tri-state enable. A stall monitor watches the bit clock and the transmit sync. If either stays at a static level for the configured window, the whole port enters power saving: both directions are silenced until a complete transmit frame runs again.

Top module: `pcm_voice_port`

## Requirements
- R1: While reset is applied and immediately after it, `rx_valid`, `tx_oe`, `tx_take` and `pwr_save` are all 0.
- R2: A receive frame starts at the first bit-clock falling edge where `rx_sync` samples 1 after having sampled 0. The next eight falling-edge samples of `rx_data` form `rx_word`, first sample in bit 7. `rx_valid` is then high for exactly one system clock cycle.
- R3: `rx_law` carries the level of `law_sel` (1 = A-law, 0 = mu-law) captured with the word. `rx_word` and `rx_law` change only in the cycle where `rx_valid` is high.
- R4: After a transmit sync is seen at a falling edge, the next rising edge loads `tx_word` and pulses `tx_take` for one cycle. `tx_data` then presents bit 7 down to bit 0, one bit per bit-clock period, changing on rising edges. `tx_oe` is high for exactly those eight periods.
- R5: A new `rx_sync` rising edge before the eighth bit restarts the receive count and discards the partial word. This includes a sync that lands in the eighth slot itself. No `rx_valid` is produced for the discarded word.
- R6: A new `tx_sync` rising edge during a transmit slot restarts transmission from bit 7 of the `tx_word` present at the next rising edge.
- R7: If `bclk` holds a static level for `STALL_CYCLES` system cycles, `pwr_save` goes to 1. While `pwr_save` is 1, `tx_oe` is 0 and no `rx_valid` pulse is produced.
- R8: If `tx_sync` holds a static level for `STALL_CYCLES` system cycles while `bclk` keeps running, `pwr_save` goes to 1.
- R9: `pwr_save` returns to 0 at the end of the first complete transmit frame during which neither watched signal is stalled. The frames after that are delivered normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bclk | input | 1 | Serial bit clock (asynchronous to clk) |
| rx_sync | input | 1 | Receive short sync strobe |
| tx_sync | input | 1 | Transmit short sync strobe |
| rx_data | input | 1 | Serial receive data |
| law_sel | input | 1 | Coding law: 1 = A-law, 0 = mu-law |
| tx_word | input | WORD_W | Sample from the encoder |
| rx_word | output | WORD_W | Last complete received sample |
| rx_valid | output | 1 | One-cycle strobe for a new `rx_word` |
| rx_law | output | 1 | Coding law captured with `rx_word` |
| tx_take | output | 1 | One-cycle strobe when `tx_word` is loaded |
| tx_data | output | 1 | Serial transmit data |
| tx_oe | output | 1 | Drive enable for `tx_data` |
| pwr_save | output | 1 | Power-save indication |

## Verification
Two receive events can fall on the same bit-clock falling edge: completion of the eighth bit and a fresh sync rising edge. The bench provokes this by raising `rx_sync` in the eighth data slot of a frame, followed by a full new word. A correct port produces exactly one `rx_valid`, and that pulse carries the second word. A similar overlap arises at the exit from power saving. Here the frame that releases `pwr_save` must itself stay silent, while the next frame must be delivered in full. The bench judges both cases by counting `rx_valid` pulses and driven transmit bits per frame.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;
   // Coding law as forwarded on rx_law.
   typedef enum logic {
      LAW_MU = 1'b0,
      LAW_A  = 1'b1
   } law_e;

   // Order of the synchronized pin vector.
   localparam int PIN_BCLK  = 0;
   localparam int PIN_RSYNC = 1;
   localparam int PIN_TSYNC = 2;
   localparam int PIN_RDATA = 3;
   localparam int PIN_LAW   = 4;
   localparam int PIN_COUNT = 5;
endpackage

// File: rtl/pcm_sync_edge.sv
module pcm_sync_edge #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q,
   output logic [W-1:0] rise,
   output logic [W-1:0] fall
);
   logic [W-1:0] pipe [STAGES];
   logic [W-1:0] last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
         last <= '0;
      end else begin
         pipe[0] <= d;
         for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
         last <= pipe[STAGES-1];
      end
   end

   assign q    = pipe[STAGES-1];
   assign rise = q & ~last;
   assign fall = ~q & last;
endmodule

// File: rtl/pcm_rx_deser.sv
module pcm_rx_deser #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         fall_evt,
   input  logic         sync_lvl,
   input  logic         data_lvl,
   input  logic         law_lvl,
   input  logic         hold,
   output logic [W-1:0] word,
   output logic         law,
   output logic         valid
);
   localparam int CW = $clog2(W);

   logic          sync_prev;
   logic          active;
   logic [CW-1:0] cnt;
   logic [W-1:0]  shreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_prev <= 1'b0;
         active    <= 1'b0;
         cnt       <= '0;
         shreg     <= '0;
         word      <= '0;
         law       <= 1'b0;
         valid     <= 1'b0;
      end else begin
         valid <= 1'b0;
         if (fall_evt) begin
            sync_prev <= sync_lvl;
            if (sync_lvl && !sync_prev) begin
               // frame start wins over any pending completion
               active <= 1'b1;
               cnt    <= '0;
            end else if (active) begin
               shreg <= {shreg[W-2:0], data_lvl};
               if (cnt == CW'(W-1)) begin
                  active <= 1'b0;
                  if (!hold) begin
                     word  <= {shreg[W-2:0], data_lvl};
                     law   <= law_lvl;
                     valid <= 1'b1;
                  end
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
         end
      end
   end
endmodule

// File: rtl/pcm_tx_ser.sv
module pcm_tx_ser #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         fall_evt,
   input  logic         rise_evt,
   input  logic         sync_lvl,
   input  logic [W-1:0] word,
   output logic         bit_out,
   output logic         oe,
   output logic         take,
   output logic         done
);
   localparam int CW = $clog2(W);

   logic          sync_prev;
   logic          armed;
   logic [CW-1:0] cnt;
   logic [W-1:0]  shreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_prev <= 1'b0;
         armed     <= 1'b0;
         cnt       <= '0;
         shreg     <= '0;
         oe        <= 1'b0;
         take      <= 1'b0;
         done      <= 1'b0;
      end else begin
         take <= 1'b0;
         done <= 1'b0;
         if (fall_evt) begin
            sync_prev <= sync_lvl;
            if (sync_lvl && !sync_prev) armed <= 1'b1;
         end
         if (rise_evt) begin
            if (armed) begin
               shreg <= word;
               oe    <= 1'b1;
               cnt   <= '0;
               armed <= 1'b0;
               take  <= 1'b1;
            end else if (oe) begin
               if (cnt == CW'(W-1)) begin
                  oe   <= 1'b0;
                  done <= 1'b1;
               end else begin
                  shreg <= {shreg[W-2:0], 1'b0};
                  cnt   <= cnt + 1'b1;
               end
            end
         end
      end
   end

   assign bit_out = shreg[W-1];
endmodule

// File: rtl/pcm_stall_mon.sv
module pcm_stall_mon #(
   parameter int LIMIT = 100000,
   parameter int SRC   = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [SRC-1:0] act,
   input  logic           frame_done,
   output logic           pwr_save
);
   localparam int CW = $clog2(LIMIT + 1);

   logic [SRC-1:0] idle;

   for (genvar g = 0; g < SRC; g++) begin : g_src
      logic [CW-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                    cnt <= '0;
         else if (act[g])               cnt <= '0;
         else if (cnt != CW'(LIMIT))    cnt <= cnt + 1'b1;
      end
      assign idle[g] = (cnt == CW'(LIMIT));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          pwr_save <= 1'b0;
      else if (|idle)      pwr_save <= 1'b1;
      else if (frame_done) pwr_save <= 1'b0;
   end
endmodule

// File: rtl/pcm_voice_port.sv
module pcm_voice_port
   import pcm_port_pkg::*;
#(
   parameter int WORD_W       = 8,
   parameter int SYNC_STAGES  = 2,
   parameter int STALL_CYCLES = 100000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bclk,
   input  logic              rx_sync,
   input  logic              tx_sync,
   input  logic              rx_data,
   input  logic              law_sel,
   input  logic [WORD_W-1:0] tx_word,
   output logic [WORD_W-1:0] rx_word,
   output logic              rx_valid,
   output logic              rx_law,
   output logic              tx_take,
   output logic              tx_data,
   output logic              tx_oe,
   output logic              pwr_save
);
   if (WORD_W < 2) begin : g_bad_w
      $error("WORD_W must be at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_s
      $error("SYNC_STAGES must be at least 2");
   end
   if (STALL_CYCLES < 16) begin : g_bad_l
      $error("STALL_CYCLES too small");
   end

   logic [PIN_COUNT-1:0] pin_raw, pin_q, pin_rise, pin_fall;
   logic                 oe_int, frame_done;
   logic [1:0]           activity;

   assign pin_raw[PIN_BCLK]  = bclk;
   assign pin_raw[PIN_RSYNC] = rx_sync;
   assign pin_raw[PIN_TSYNC] = tx_sync;
   assign pin_raw[PIN_RDATA] = rx_data;
   assign pin_raw[PIN_LAW]   = law_sel;

   pcm_sync_edge #(.W(PIN_COUNT), .STAGES(SYNC_STAGES)) u_sync (
      .clk (clk), .rst_n (rst_n), .d (pin_raw),
      .q (pin_q), .rise (pin_rise), .fall (pin_fall)
   );

   pcm_rx_deser #(.W(WORD_W)) u_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .fall_evt (pin_fall[PIN_BCLK]),
      .sync_lvl (pin_q[PIN_RSYNC]),
      .data_lvl (pin_q[PIN_RDATA]),
      .law_lvl  (pin_q[PIN_LAW]),
      .hold     (pwr_save),
      .word     (rx_word),
      .law      (rx_law),
      .valid    (rx_valid)
   );

   pcm_tx_ser #(.W(WORD_W)) u_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .fall_evt (pin_fall[PIN_BCLK]),
      .rise_evt (pin_rise[PIN_BCLK]),
      .sync_lvl (pin_q[PIN_TSYNC]),
      .word     (tx_word),
      .bit_out  (tx_data),
      .oe       (oe_int),
      .take     (tx_take),
      .done     (frame_done)
   );

   assign activity[0] = pin_rise[PIN_BCLK]  | pin_fall[PIN_BCLK];
   assign activity[1] = pin_rise[PIN_TSYNC] | pin_fall[PIN_TSYNC];

   pcm_stall_mon #(.LIMIT(STALL_CYCLES), .SRC(2)) u_stall (
      .clk        (clk),
      .rst_n      (rst_n),
      .act        (activity),
      .frame_done (frame_done),
      .pwr_save   (pwr_save)
   );

   assign tx_oe = oe_int & ~pwr_save;
endmodule

// File: rtl/pcm_voice_port_chk.sv
module pcm_voice_port_chk #(
   parameter int WORD_W       = 8,
   parameter int SYNC_STAGES  = 2,
   parameter int STALL_CYCLES = 100000
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bclk,
   input logic [WORD_W-1:0] rx_word,
   input logic              rx_valid,
   input logic              rx_law,
   input logic              tx_take,
   input logic              tx_oe,
   input logic              pwr_save
);
   localparam int MARGIN = STALL_CYCLES + SYNC_STAGES + 4;

   logic bclk_d;
   int   still;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bclk_d <= 1'b0;
         still  <= 0;
      end else begin
         bclk_d <= bclk;
         if (bclk != bclk_d)   still <= 0;
         else if (still < MARGIN) still <= still + 1;
      end
   end

   p_valid_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);

   p_word_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_valid |-> ($stable(rx_word) && $stable(rx_law)));

   p_take_drives_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_take && !pwr_save) |-> tx_oe);

   p_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_save |-> (!tx_oe && !rx_valid));

   p_bclk_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (still >= MARGIN) |-> pwr_save);
endmodule

bind pcm_voice_port pcm_voice_port_chk #(
   .WORD_W(WORD_W), .SYNC_STAGES(SYNC_STAGES), .STALL_CYCLES(STALL_CYCLES)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bclk     (bclk),
   .rx_word  (rx_word),
   .rx_valid (rx_valid),
   .rx_law   (rx_law),
   .tx_take  (tx_take),
   .tx_oe    (tx_oe),
   .pwr_save (pwr_save)
);

// File: tb/sim_pcm_voice_port.sv
module sim_pcm_voice_port;
   localparam int CLK_PERIOD = 10;
   localparam int HALF       = 8;
   localparam int STALL      = 500;
   localparam int W          = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         bclk = 1'b0, rx_sync = 1'b0, tx_sync = 1'b0, rx_data = 1'b0, law_sel = 1'b0;
   logic [W-1:0] tx_word = '0;
   logic [W-1:0] rx_word;
   logic         rx_valid, rx_law, tx_take, tx_data, tx_oe, pwr_save;

   always #(CLK_PERIOD/2) clk = ~clk;

   pcm_voice_port #(.WORD_W(W), .SYNC_STAGES(2), .STALL_CYCLES(STALL)) u0 (
      .clk (clk), .rst_n (rst_n), .bclk (bclk), .rx_sync (rx_sync),
      .tx_sync (tx_sync), .rx_data (rx_data), .law_sel (law_sel),
      .tx_word (tx_word), .rx_word (rx_word), .rx_valid (rx_valid),
      .rx_law (rx_law), .tx_take (tx_take), .tx_data (tx_data),
      .tx_oe (tx_oe), .pwr_save (pwr_save)
   );

   int           vecs = 0, errs = 0;
   int           rxn = 0, takes = 0, txn = 0;
   logic [W-1:0] rxcap = '0, txcap = '0;
   logic         rxlaw = 1'b0;
   bit           finished = 1'b0;

   // {law, rx byte, tx byte}
   localparam logic [16:0] VEC [6] = '{
      {1'b0, 8'hA5, 8'h3C}, {1'b1, 8'h00, 8'hFF}, {1'b1, 8'hFF, 8'h00},
      {1'b0, 8'h81, 8'h7E}, {1'b1, 8'h5A, 8'hC3}, {1'b0, 8'h01, 8'h80}
   };

   always @(negedge clk) begin
      if (rst_n) begin
         if (rx_valid) begin rxn++; rxcap = rx_word; rxlaw = rx_law; end
         if (tx_take) takes++;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      vecs++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // one bit-clock period; data and syncs change with the rising edge
   task automatic bitp(input logic d, input logic rs, input logic ts);
      bclk = 1'b1; rx_data = d; rx_sync = rs; tx_sync = ts;
      repeat (HALF) @(negedge clk);
      if (tx_oe) begin txcap = {txcap[W-2:0], tx_data}; txn++; end
      bclk = 1'b0;
      repeat (HALF) @(negedge clk);
   endtask

   task automatic frame(input logic [W-1:0] rb, input logic lw);
      law_sel = lw;
      bitp(1'b0, 1'b1, 1'b1);
      for (int i = W-1; i >= 0; i--) bitp(rb[i], 1'b0, 1'b0);
      for (int i = 0; i < 3; i++) bitp(1'b0, 1'b0, 1'b0);
   endtask

   initial begin
      repeat (STALL * 300) @(posedge clk);
      if (!finished) begin
         errs++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
         $finish;
      end
   end

   initial begin
      int r0, t0, k0;
      repeat (3) @(negedge clk);
      // R1: outputs quiet during reset
      chk("R1 rst valid/oe/take/ps", {rx_valid, tx_oe, tx_take, pwr_save}, 4'b0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R1 post-reset outputs", {rx_valid, tx_oe, tx_take, pwr_save}, 4'b0);

      // table walk: R2, R3, R4
      for (int v = 0; v < 6; v++) begin
         r0 = rxn; t0 = txn; k0 = takes;
         tx_word = VEC[v][7:0];
         frame(VEC[v][15:8], VEC[v][16]);
         chk("R2 rx pulses", rxn - r0, 1);
         chk("R2 rx word", rxcap, VEC[v][15:8]);
         chk("R3 rx law", rxlaw, VEC[v][16]);
         chk("R4 tx bit count", txn - t0, 8);
         chk("R4 tx word", txcap, VEC[v][7:0]);
         chk("R4 take pulses", takes - k0, 1);
      end

      // R5: early sync restarts receive
      r0 = rxn;
      bitp(1'b0, 1'b1, 1'b1);
      for (int i = 0; i < 4; i++) bitp(1'b1, 1'b0, 1'b0);
      bitp(1'b0, 1'b1, 1'b0);
      for (int i = W-1; i >= 0; i--) bitp(8'h6B >> i, 1'b0, 1'b0);
      for (int i = 0; i < 3; i++) bitp(1'b0, 1'b0, 1'b0);
      chk("R5 restart pulses", rxn - r0, 1);
      chk("R5 restart word", rxcap, 8'h6B);

      // R5: sync in the eighth slot collides with completion
      r0 = rxn;
      bitp(1'b0, 1'b1, 1'b1);
      for (int i = 0; i < 7; i++) bitp(1'b1, 1'b0, 1'b0);
      bitp(1'b1, 1'b1, 1'b0);
      for (int i = W-1; i >= 0; i--) bitp(8'h92 >> i, 1'b0, 1'b0);
      for (int i = 0; i < 3; i++) bitp(1'b0, 1'b0, 1'b0);
      chk("R5 same-slot pulses", rxn - r0, 1);
      chk("R5 same-slot word", rxcap, 8'h92);

      // R6: transmit restart picks up the current word
      t0 = txn; k0 = takes;
      tx_word = 8'hE1;
      bitp(1'b0, 1'b0, 1'b1);
      bitp(1'b0, 1'b0, 1'b0);
      tx_word = 8'h4D;
      bitp(1'b0, 1'b0, 1'b0);
      bitp(1'b0, 1'b0, 1'b0);
      bitp(1'b0, 1'b0, 1'b1);
      for (int i = 0; i < W + 2; i++) bitp(1'b0, 1'b0, 1'b0);
      chk("R6 take pulses", takes - k0, 2);
      chk("R6 bits driven", txn - t0, 12);
      chk("R6 restarted word", txcap, 8'h4D);

      // R7: bit clock stopped
      bclk = 1'b0; tx_sync = 1'b0;
      repeat (STALL + 200) @(negedge clk);
      chk("R7 bclk stall ps", pwr_save, 1'b1);
      chk("R7 tx_oe off", tx_oe, 1'b0);

      // R7/R9: recovery frame is silent, then releases
      r0 = rxn; t0 = txn;
      tx_word = 8'h33;
      frame(8'hC7, 1'b1);
      chk("R7 no rx in ps", rxn - r0, 0);
      chk("R7 no tx in ps", txn - t0, 0);
      chk("R9 ps released", pwr_save, 1'b0);
      r0 = rxn; t0 = txn;
      tx_word = 8'h9C;
      frame(8'h2E, 1'b0);
      chk("R9 rx after release", rxcap, 8'h2E);
      chk("R9 rx pulse after release", rxn - r0, 1);
      chk("R9 tx after release", txcap, 8'h9C);

      // R8: transmit sync stalled, bit clock running
      for (int i = 0; i < 45; i++) bitp(1'b0, 1'b0, 1'b0);
      chk("R8 tsync stall ps", pwr_save, 1'b1);
      frame(8'h11, 1'b0);
      chk("R9 ps released after tsync", pwr_save, 1'b0);

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
   end
endmodule